// File: doc/BRIEF.md
# Comparator Output Window and Filter

This block turns the raw, asynchronous result bit of an analog comparator into a clean digital level in the peripheral clock domain. The bit first passes through a multi-stage synchronizer. An optional window stage then either passes the synchronized bit straight through or tracks it only while a gate input is high, holding the last tracked value while the gate is low.

An optional digital filter follows the window stage. It looks at the bit only on sample events and accepts a new level only after a programmed number of consecutive events agree on it. Sample events come either from rising edges of an external strobe or from an internal divider that fires once every programmed number of peripheral clocks. The window and the external strobe may not both be enabled. If software sets both, the window wins and the internal divider drives the filter.

Top module: `cmpout_cond`

## Requirements
- R1: While reset is asserted, `win_out` and `flt_out` are 0, even with `cmp_raw` held at 1.
- R2: With `win_en`=0, `win_out` equals `cmp_raw` delayed by exactly SYNC_STAGES (default 2) clocks, and `win_gate` has no effect.
- R3: With `win_en`=1, `win_out` tracks the synchronized bit on clocks where `win_gate`=1 and holds its value while `win_gate`=0. After the gate rises, the held value updates one clock later.
- R4: With `flt_count`=0, the filter is bypassed and `flt_out` equals `win_out` in the same cycle.
- R5: With internal sampling selected and `flt_period`=0, the filter is bypassed. In external mode, `flt_period`=0 does not bypass it.
- R6: With `flt_count`=1, the filter is a plain sampler: `flt_out` takes `win_out` at the next sample event.
- R7: With `flt_count`=N>1, `flt_out` changes only after N consecutive sample events see a level different from `flt_out`. A sample equal to `flt_out` restarts the run. From a change at `cmp_raw`, the output follows within 2+(N-1)*P+1 to 2+N*P clocks when the internal period is P.
- R8: With internal sampling, sample events occur exactly once every `flt_period` clocks. A sampler that has just updated responds to a new input exactly `flt_period` clocks later when `flt_period`>=3.
- R9: With `ext_sel`=1 and `win_en`=0, each rising edge of `ext_strobe` gives exactly one sample event, however long the strobe stays high. No edges means no filter updates.
- R10: With `win_en`=1 and `ext_sel`=1, the external strobe is ignored and the internal divider provides sample events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_raw | input | 1 | Asynchronous comparator result bit |
| win_gate | input | 1 | Window gate; tracking happens while high |
| ext_strobe | input | 1 | External sample strobe, asynchronous |
| win_en | input | 1 | Enables the window stage |
| ext_sel | input | 1 | Selects the external strobe as sample source |
| flt_count | input | CNT_W (3) | Consecutive agreeing samples required; 0 bypasses |
| flt_period | input | PER_W (8) | Internal divider period in clocks; 0 bypasses in internal mode |
| win_out | output | 1 | Windowed comparator level |
| flt_out | output | 1 | Filtered comparator level |

## Verification
A corrupt divider count shifts the moment `flt_out` answers an input change, so the exact-interval test sees it within one divider period. A run counter that fails to restart lets short glitches through to `flt_out` within a few sample events. A window register that updates while the gate is low shows up at `win_out` on the next clock. A broken edge detector on the strobe path turns one long strobe pulse into several events, and the output then flips after a single pulse when it should need two.

// File: rtl/cmpout_pkg.sv
package cmpout_pkg;

  typedef enum logic {
    SRC_DIV = 1'b0,
    SRC_EXT = 1'b1
  } smp_src_e;

  // Filter bypass rule: no count, or internal source with no period.
  function automatic logic filt_bypass(input logic cnt_zero,
                                       input logic per_zero,
                                       input smp_src_e src);
    return cnt_zero || (per_zero && (src == SRC_DIV));
  endfunction

  // Sample source selection: the window enable takes priority.
  function automatic smp_src_e pick_src(input logic win_en,
                                        input logic ext_sel);
    return (ext_sel && !win_en) ? SRC_EXT : SRC_DIV;
  endfunction

endpackage

// File: rtl/cmpout_sync.sv
module cmpout_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cmpout_strobe.sv
module cmpout_strobe
  import cmpout_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PER_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  smp_src_e         src,
  input  logic             ext_strobe,
  input  logic [PER_W-1:0] period,
  output logic             evt
);
  localparam logic [PER_W-1:0] ONE_P = PER_W'(1);

  // Next divider count: wraps at period-1, parks at 0 when period is 0.
  function automatic logic [PER_W-1:0] div_next(input logic [PER_W-1:0] cnt,
                                                input logic [PER_W-1:0] per);
    if (per == '0)             return '0;
    else if (cnt >= per - ONE_P) return '0;
    else                       return cnt + ONE_P;
  endfunction

  logic             ext_s;
  logic             ext_d;
  logic             ext_rise;
  logic [PER_W-1:0] div_cnt;
  logic             div_evt;

  cmpout_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (ext_strobe),
    .q    (ext_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_d <= 1'b0;
    else        ext_d <= ext_s;
  end

  assign ext_rise = ext_s && !ext_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_cnt <= '0;
    else        div_cnt <= div_next(div_cnt, period);
  end

  assign div_evt = (period != '0) && (div_cnt == period - ONE_P);

  assign evt = (src == SRC_EXT) ? ext_rise : div_evt;

  AST_EXT_ONE_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && src == SRC_EXT) |=> !(evt && src == SRC_EXT)); // R9

  AST_DIV_EVT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (div_evt && period > ONE_P) |=> (!div_evt || period != $past(period))); // R8
endmodule

// File: rtl/cmpout_window.sv
module cmpout_window (
  input  logic clk,
  input  logic rst_n,
  input  logic win_en,
  input  logic win_gate,
  input  logic d,
  output logic q
);
  logic held;
  logic track;

  // Track every clock while the window is off, so enabling it starts from the current level.
  assign track = !win_en || win_gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     held <= 1'b0;
    else if (track) held <= d;
  end

  assign q = win_en ? held : d;

  AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (win_en && !win_gate) |=> (!win_en || $stable(q))); // R3
endmodule

// File: rtl/cmpout_filter.sv
module cmpout_filter #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bypass,
  input  logic             evt,
  input  logic             d,
  input  logic [CNT_W-1:0] need,
  output logic             q
);
  localparam logic [CNT_W:0] ONE_C = (CNT_W+1)'(1);

  logic [CNT_W:0] run;
  logic [CNT_W:0] run_inc;
  logic           q_reg;
  logic           differs;
  logic           accept;

  // Length of the agreeing run including the present sample.
  function automatic logic [CNT_W:0] run_step(input logic [CNT_W:0] r);
    return r + ONE_C;
  endfunction

  assign differs = (d != q_reg);
  assign run_inc = run_step(run);
  assign accept  = evt && differs && (run_inc >= {1'b0, need});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_reg <= 1'b0;
      run   <= '0;
    end else if (bypass) begin
      q_reg <= d;
      run   <= '0;
    end else if (evt) begin
      if (accept) begin
        q_reg <= d;
        run   <= '0;
      end else if (differs) begin
        run <= run_inc;
      end else begin
        run <= '0;
      end
    end
  end

  assign q = bypass ? d : q_reg;

  AST_FLT_MOVES_ON_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    !bypass |=> (bypass || $stable(q_reg) || $past(evt))); // R6

  AST_FLT_RUN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && evt && !differs) |=> (run == '0)); // R7
endmodule

// File: rtl/cmpout_cond.sv
module cmpout_cond
  import cmpout_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 3,
  parameter int PER_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_raw,
  input  logic             win_gate,
  input  logic             ext_strobe,
  input  logic             win_en,
  input  logic             ext_sel,
  input  logic [CNT_W-1:0] flt_count,
  input  logic [PER_W-1:0] flt_period,
  output logic             win_out,
  output logic             flt_out
);
  smp_src_e src;
  logic     cmp_s;
  logic     smp_evt;
  logic     bypass;

  assign src    = pick_src(win_en, ext_sel);
  assign bypass = filt_bypass(flt_count == '0, flt_period == '0, src);

  cmpout_sync #(.STAGES(SYNC_STAGES)) u_cmp_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (cmp_raw),
    .q    (cmp_s)
  );

  cmpout_window u_window (
    .clk     (clk),
    .rst_n   (rst_n),
    .win_en  (win_en),
    .win_gate(win_gate),
    .d       (cmp_s),
    .q       (win_out)
  );

  cmpout_strobe #(.SYNC_STAGES(SYNC_STAGES), .PER_W(PER_W)) u_strobe (
    .clk       (clk),
    .rst_n     (rst_n),
    .src       (src),
    .ext_strobe(ext_strobe),
    .period    (flt_period),
    .evt       (smp_evt)
  );

  cmpout_filter #(.CNT_W(CNT_W)) u_filter (
    .clk   (clk),
    .rst_n (rst_n),
    .bypass(bypass),
    .evt   (smp_evt),
    .d     (win_out),
    .need  (flt_count),
    .q     (flt_out)
  );

  AST_WE_BLOCKS_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (win_en && ext_sel && $stable(flt_period) && flt_period == '0 && flt_count != '0)
      |-> (flt_out == win_out)); // R10
endmodule

// File: tb/cmpout_cond_tb.sv
module cmpout_cond_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp_raw = 1'b0;
  logic       win_gate = 1'b0;
  logic       ext_strobe = 1'b0;
  logic       win_en = 1'b0;
  logic       ext_sel = 1'b0;
  logic [2:0] flt_count = 3'd0;
  logic [7:0] flt_period = 8'd0;
  logic       win_out;
  logic       flt_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  cmpout_cond dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_raw   (cmp_raw),
    .win_gate  (win_gate),
    .ext_strobe(ext_strobe),
    .win_en    (win_en),
    .ext_sel   (ext_sel),
    .flt_count (flt_count),
    .flt_period(flt_period),
    .win_out   (win_out),
    .flt_out   (flt_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_range(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d..%0d at %0t", req, act, lo, hi, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic we, input logic se, input logic [2:0] cnt,
                          input logic [7:0] per);
    @(negedge clk);
    rst_n = 1'b0;
    cmp_raw = 1'b0; win_gate = 1'b0; ext_strobe = 1'b0;
    win_en = we; ext_sel = se; flt_count = cnt; flt_period = per;
    tick(3);
    rst_n = 1'b1;
    tick(4);
  endtask

  // Count negedges until flt_out reaches the wanted level (cap guards a hang).
  task automatic wait_flt(input logic lvl, input int cap, output int n);
    n = 0;
    while (n < cap) begin
      @(negedge clk);
      n++;
      if (flt_out == lvl) break;
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst_n = 1'b0;
    cmp_raw = 1'b1;
    flt_count = 3'd0;
    tick(4);
    chk("R1 win_out in reset", win_out, 0);
    chk("R1 flt_out in reset", flt_out, 0);
    cmp_raw = 1'b0;
  endtask

  task automatic t_pass_delay;
    do_reset(1'b0, 1'b0, 3'd0, 8'd0);
    win_gate = 1'b0;
    cmp_raw = 1'b1;
    tick(1);
    chk("R2 one clock after rise", win_out, 0);
    tick(1);
    chk("R2 two clocks after rise", win_out, 1);
    cmp_raw = 1'b0;
    tick(1);
    chk("R2 one clock after fall", win_out, 1);
    tick(1);
    chk("R2 two clocks after fall", win_out, 0);
  endtask

  task automatic t_window;
    do_reset(1'b1, 1'b0, 3'd0, 8'd0);
    win_gate = 1'b1;
    cmp_raw = 1'b1;
    tick(4);
    chk("R3 gate open tracks", win_out, 1);
    win_gate = 1'b0;
    cmp_raw = 1'b0;
    tick(6);
    chk("R3 gate closed holds", win_out, 1);
    win_gate = 1'b1;
    tick(1);
    chk("R3 gate reopened updates", win_out, 0);
  endtask

  task automatic t_bypass_count;
    logic [11:0] pat = 12'b1011_0010_1110;
    do_reset(1'b0, 1'b0, 3'd0, 8'd3);
    for (int i = 0; i < 12; i++) begin
      cmp_raw = pat[i];
      tick(1);
      chk("R4 count zero bypass", flt_out, win_out);
    end
  endtask

  task automatic t_bypass_period;
    logic [11:0] pat = 12'b0110_1001_1101;
    do_reset(1'b0, 1'b0, 3'd2, 8'd0);
    for (int i = 0; i < 12; i++) begin
      cmp_raw = pat[i];
      tick(1);
      chk("R5 period zero bypass", flt_out, win_out);
    end
  endtask

  task automatic t_sampler;
    int n;
    do_reset(1'b0, 1'b0, 3'd1, 8'd4);
    cmp_raw = 1'b1;
    wait_flt(1'b1, 40, n);
    chk_range("R6 sampler rise latency", n, 3, 6);
  endtask

  task automatic t_period_exact;
    int n;
    do_reset(1'b0, 1'b0, 3'd1, 8'd5);
    cmp_raw = 1'b1;
    wait_flt(1'b1, 40, n);
    cmp_raw = 1'b0;
    wait_flt(1'b0, 40, n);
    chk("R8 response one period later", n, 5);
  endtask

  task automatic t_multi;
    int n;
    do_reset(1'b0, 1'b0, 3'd3, 8'd2);
    cmp_raw = 1'b1;
    for (int i = 0; i < 4; i++) begin tick(1); chk("R7 short pulse rejected", flt_out, 0); end
    cmp_raw = 1'b0;
    for (int i = 0; i < 2; i++) begin tick(1); chk("R7 run restart low", flt_out, 0); end
    cmp_raw = 1'b1;
    for (int i = 0; i < 4; i++) begin tick(1); chk("R7 second pulse rejected", flt_out, 0); end
    cmp_raw = 1'b0;
    for (int i = 0; i < 8; i++) begin tick(1); chk("R7 stays low", flt_out, 0); end
    cmp_raw = 1'b1;
    wait_flt(1'b1, 60, n);
    chk_range("R7 accepted after three samples", n, 2 + 2*2 + 1, 2 + 3*2);
  endtask

  task automatic t_external;
    do_reset(1'b0, 1'b1, 3'd2, 8'd0);
    cmp_raw = 1'b1;
    tick(8);
    chk("R9 no strobe no update", flt_out, 0);
    chk("R5 external mode not bypassed", win_out, 1);
    ext_strobe = 1'b1;
    tick(10);
    chk("R9 long strobe counts once", flt_out, 0);
    ext_strobe = 1'b0;
    tick(4);
    ext_strobe = 1'b1;
    tick(6);
    chk("R9 second edge accepts", flt_out, 1);
    ext_strobe = 1'b0;
  endtask

  task automatic t_priority;
    do_reset(1'b1, 1'b1, 3'd1, 8'd3);
    win_gate = 1'b1;
    ext_strobe = 1'b0;
    cmp_raw = 1'b1;
    tick(10);
    chk("R10 window wins, divider samples", flt_out, 1);
    chk("R10 window output", win_out, 1);
  endtask

  initial begin
    t_reset();
    t_pass_delay();
    t_window();
    t_bypass_count();
    t_bypass_period();
    t_sampler();
    t_period_exact();
    t_multi();
    t_external();
    t_priority();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule